// File: doc/BRIEF.md
# Hash Accelerator Data Intake Front-End

This block sits between a system bus and a hash compression core. Software configures it and monitors it through one 32-bit control/status register. It streams message data into a separate data port using 8-, 16- or full-width writes. Each write appends its bytes at the current position of a 64-byte message block. A write may first reverse the byte order of the bus word, so that little-endian bus data reaches the core in the big-endian order the hash needs.

When the block holds 64 bytes it is offered to the compression core with a valid/busy handshake. The front-end then refuses further data until the core reports completion. A data write made while intake is stalled is dropped and raises a sticky error. The error stays set until software clears it, and clearing it also rewinds a partly filled block. A digest-valid flag follows the block boundaries. The core's 256-bit digest can be read back one 32-bit word at a time. A start command prepares for a new message: it rewinds the byte count and tells the core to load its initial hash value.

Top module: `hash_intake`

## Requirements
- R1: After reset `csr_rdata` reads 0x0000_1004. Byte swap (bit 12) is on, ready (bit 2) is high, the size field (bits 5:4) is 0, and the error (bit 1), sum-valid (bit 3) and start (bit 0) bits are 0. `blk_valid` and `core_init` are low.
- R2: Size field code 0 writes 1 byte, code 1 writes 2 bytes, and codes 2 and 3 write 4 bytes. The bytes are placed at consecutive block positions starting at the current byte count. Position i appears at `blk_data[511-8*i -: 8]`, so position 0 is the most significant byte.
- R3: With byte swap off, an n-byte write enters the stream most significant byte first: `dat_wdata[8*(n-1)+:8]` first, down to `dat_wdata[7:0]`. With byte swap on, lane 0 (`dat_wdata[7:0]`) enters first, then lane 1, and so on. In both cases only the low n lanes are used.
- R4: The cycle after the write that brings the count to 64 or beyond, `blk_valid` is high and ready is low. Bytes of that write beyond position 63 are discarded. While ready is low, `blk_data` does not change.
- R5: `blk_valid` stays high until a cycle in which `core_busy` is low, and that cycle hands over the block. The front-end then waits for `core_busy` to be low again, and ready returns high the following cycle. Ready is high throughout block filling.
- R6: A data write while ready is low is dropped and sets error bit 1. The bit stays set until a CSR write with bit 1 = 1, which clears it and also returns a partly filled block's byte count to 0.
- R7: Sum-valid bit 3 goes high together with ready when a block's compression ends. It goes low the cycle after the first accepted data write of the next block, and also on a start.
- R8: Writing 1 to start bit 0 while ready is high zeroes the byte count and clears sum-valid, and pulses `core_init` for one cycle on the following cycle. While ready is low a start is ignored. The start bit always reads 0.
- R9: Every CSR write updates the size field and byte swap bit 12. A size change in the middle of a block keeps the byte count already collected.
- R10: `rd_word` equals digest word `rd_idx`, where word 0 is `core_digest[255:224]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Control/status register write strobe |
| csr_wdata | input | 32 | Control/status register write value |
| csr_rdata | output | 32 | Control/status register read value |
| dat_we | input | 1 | Message data write strobe |
| dat_wdata | input | 32 | Message data write value |
| blk_valid | output | 1 | Full block offered to the compression core |
| blk_data | output | 512 | Message block, position 0 in the top byte |
| core_busy | input | 1 | Compression core is working |
| core_init | output | 1 | One-cycle request to load the initial hash value |
| core_digest | input | 256 | Digest from the compression core |
| rd_idx | input | 3 | Digest word select |
| rd_word | output | 32 | Selected digest word |

## Verification
The assertions take for granted that the core raises `core_busy` in the cycle after it accepts a block and holds it high for at least that cycle. They also assume that a CSR write and a data write never arrive in the same cycle. The bench core model follows that contract, with a fixed latency, and an extra busy override holds a block at the handshake. Every bench task drives a single strobe per cycle, so no data write ever collides with a CSR write.

// File: rtl/hash_intake_pkg.sv
`timescale 1ns/1ps
package hash_intake_pkg;

   // Control/status register bit positions
   localparam int CSR_START  = 0;
   localparam int CSR_ERR    = 1;
   localparam int CSR_RDY    = 2;
   localparam int CSR_SUM    = 3;
   localparam int CSR_SZ_LSB = 4;
   localparam int CSR_SZ_W   = 2;
   localparam int CSR_BSWAP  = 12;

   typedef enum logic [1:0] {
      ST_FILL = 2'd0,
      ST_SEND = 2'd1,
      ST_WAIT = 2'd2
   } intake_st_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_FULL = 2'd3
   } xfer_sz_e;

endpackage

// File: rtl/hi_lane_order.sv
`timescale 1ns/1ps
module hi_lane_order #(
   parameter int BUS_BYTES = 4,
   parameter int NW        = $clog2(BUS_BYTES + 1),
   parameter int LW        = $clog2(BUS_BYTES)
) (
   input  logic [BUS_BYTES*8-1:0] data,
   input  logic [NW-1:0]          nbytes,
   input  logic                   swap,
   output logic [BUS_BYTES*8-1:0] stream
);

   for (genvar k = 0; k < BUS_BYTES; k++) begin : g_slot
      logic [7:0]    s;
      logic [LW-1:0] ri;
      always_comb begin
         ri = LW'(int'(nbytes) - 1 - k);
         if (k >= int'(nbytes)) begin
            s = '0;
         end else if (swap) begin
            s = data[k*8 +: 8];
         end else begin
            s = data[ri*8 +: 8];
         end
      end
      assign stream[k*8 +: 8] = s;
   end

endmodule

// File: rtl/hi_block_buf.sv
`timescale 1ns/1ps
module hi_block_buf #(
   parameter int BLOCK_BYTES = 64,
   parameter int BUS_BYTES   = 4,
   parameter int CW          = $clog2(BLOCK_BYTES + 1),
   parameter int NW          = $clog2(BUS_BYTES + 1),
   parameter int LW          = $clog2(BUS_BYTES)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [CW-1:0]            pos,
   input  logic [NW-1:0]            nbytes,
   input  logic [BUS_BYTES*8-1:0]   stream,
   output logic [BLOCK_BYTES*8-1:0] block
);

   for (genvar i = 0; i < BLOCK_BYTES; i++) begin : g_byte
      logic [7:0]    q;
      logic          hit;
      logic [LW-1:0] sel;
      int            off;
      always_comb begin
         off = i - int'(pos);
         hit = wr_en && (off >= 0) && (off < int'(nbytes));
         sel = LW'(off);
      end
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q <= '0;
         end else if (hit) begin
            q <= stream[sel*8 +: 8];
         end
      end
      assign block[(BLOCK_BYTES-1-i)*8 +: 8] = q;
   end

endmodule

// File: rtl/hi_ctrl.sv
`timescale 1ns/1ps
module hi_ctrl
   import hash_intake_pkg::*;
#(
   parameter int BLOCK_BYTES = 64,
   parameter int BUS_BYTES   = 4,
   parameter int CW          = $clog2(BLOCK_BYTES + 1),
   parameter int NW          = $clog2(BUS_BYTES + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                csr_we,
   input  logic [31:0]         csr_wdata,
   input  logic                dat_we,
   input  logic                core_busy,
   output logic                rdy,
   output logic                blk_valid,
   output logic                wr_en,
   output logic [CW-1:0]       pos,
   output logic [NW-1:0]       nbytes,
   output logic                swap,
   output logic                err,
   output logic                sum_vld,
   output logic [CSR_SZ_W-1:0] size,
   output logic                core_init
);

   intake_st_e          st_q;
   logic [CW-1:0]       cnt_q;
   logic [CW:0]         cnt_sum;
   logic                full;
   logic                err_q, sum_q, swap_q, init_q;
   logic [CSR_SZ_W-1:0] sz_q;
   logic                start_req, clr_req, bad_wr, done;

   logic unused_csr_bits;
   assign unused_csr_bits = ^{csr_wdata[31:CSR_BSWAP+1],
                              csr_wdata[CSR_BSWAP-1:CSR_SZ_LSB+CSR_SZ_W],
                              csr_wdata[CSR_SUM:CSR_RDY]};

   // transfer size decode; the top code selects the full bus width
   always_comb begin
      int n;
      n = 1 << sz_q;
      if (sz_q == SZ_FULL) n = BUS_BYTES;
      if (n > BUS_BYTES)   n = BUS_BYTES;
      nbytes = NW'(n);
   end

   assign start_req = csr_we && csr_wdata[CSR_START] && (st_q == ST_FILL);
   assign clr_req   = csr_we && csr_wdata[CSR_ERR];
   assign bad_wr    = dat_we && (st_q != ST_FILL);
   assign wr_en     = dat_we && (st_q == ST_FILL) && !start_req && !clr_req;
   assign cnt_sum   = {1'b0, cnt_q} + (CW+1)'(nbytes);
   assign full      = cnt_sum >= (CW+1)'(BLOCK_BYTES);
   assign done      = (st_q == ST_WAIT) && !core_busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_FILL;
         cnt_q  <= '0;
         err_q  <= 1'b0;
         sum_q  <= 1'b0;
         swap_q <= 1'b1;
         sz_q   <= SZ_BYTE;
         init_q <= 1'b0;
      end else begin
         init_q <= start_req;
         if (csr_we) begin
            sz_q   <= csr_wdata[CSR_SZ_LSB +: CSR_SZ_W];
            swap_q <= csr_wdata[CSR_BSWAP];
         end
         if (bad_wr) begin
            err_q <= 1'b1;
         end else if (clr_req) begin
            err_q <= 1'b0;
         end
         if (start_req) begin
            sum_q <= 1'b0;
         end else if (done) begin
            sum_q <= 1'b1;
         end else if (wr_en && (cnt_q == '0)) begin
            sum_q <= 1'b0;
         end
         case (st_q)
            ST_FILL: begin
               if (start_req || clr_req) begin
                  cnt_q <= '0;
               end else if (wr_en) begin
                  if (full) begin
                     cnt_q <= CW'(BLOCK_BYTES);
                     st_q  <= ST_SEND;
                  end else begin
                     cnt_q <= cnt_sum[CW-1:0];
                  end
               end
            end
            ST_SEND: begin
               if (!core_busy) st_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (!core_busy) begin
                  st_q  <= ST_FILL;
                  cnt_q <= '0;
               end
            end
            default: st_q <= ST_FILL;
         endcase
      end
   end

   assign rdy       = (st_q == ST_FILL);
   assign blk_valid = (st_q == ST_SEND);
   assign pos       = cnt_q;
   assign swap      = swap_q;
   assign err       = err_q;
   assign sum_vld   = sum_q;
   assign size      = sz_q;
   assign core_init = init_q;

   // R6: a stalled data write raises the error
   a_r6_err_set: assert property (@(posedge clk) disable iff (!rst_n)
      dat_we && !rdy |=> err);

   // R6: the error holds until an explicit clear
   a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err && !(csr_we && csr_wdata[CSR_ERR]) |=> err);

   // R5: an offered block stays offered while the core is busy
   a_r5_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
      blk_valid && core_busy |=> blk_valid);

   // R4: the byte count never passes the block size
   a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(BLOCK_BYTES));

   // R7: sum-valid only rises as intake reopens
   a_r7_sum_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sum_vld) |-> $rose(rdy));

   // R8: a start while stalled produces no init pulse
   a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      csr_we && csr_wdata[CSR_START] && !rdy |=> !core_init);

endmodule

// File: rtl/hash_intake.sv
`timescale 1ns/1ps
module hash_intake
   import hash_intake_pkg::*;
#(
   parameter int BLOCK_BYTES  = 64,
   parameter int BUS_BYTES    = 4,
   parameter int DIGEST_WORDS = 8,
   parameter int CW           = $clog2(BLOCK_BYTES + 1),
   parameter int NW           = $clog2(BUS_BYTES + 1),
   parameter int IW           = $clog2(DIGEST_WORDS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      csr_we,
   input  logic [31:0]               csr_wdata,
   output logic [31:0]               csr_rdata,
   input  logic                      dat_we,
   input  logic [BUS_BYTES*8-1:0]    dat_wdata,
   output logic                      blk_valid,
   output logic [BLOCK_BYTES*8-1:0]  blk_data,
   input  logic                      core_busy,
   output logic                      core_init,
   input  logic [DIGEST_WORDS*32-1:0] core_digest,
   input  logic [IW-1:0]             rd_idx,
   output logic [31:0]               rd_word
);

   initial begin
      a_cfg_bus_pow2: assert (BUS_BYTES >= 2 && (BUS_BYTES & (BUS_BYTES - 1)) == 0)
         else $error("BUS_BYTES must be a power of two, at least 2");
      a_cfg_block_mult: assert (BLOCK_BYTES % BUS_BYTES == 0)
         else $error("BLOCK_BYTES must be a multiple of BUS_BYTES");
      a_cfg_digest_pow2: assert (DIGEST_WORDS >= 2 && (DIGEST_WORDS & (DIGEST_WORDS - 1)) == 0)
         else $error("DIGEST_WORDS must be a power of two, at least 2");
   end

   logic                rdy, wr_en, swap, err, sum_vld;
   logic [CW-1:0]       pos;
   logic [NW-1:0]       nbytes;
   logic [CSR_SZ_W-1:0] size;
   logic [BUS_BYTES*8-1:0] stream;
   logic [IW-1:0]       widx;

   hi_ctrl #(
      .BLOCK_BYTES (BLOCK_BYTES),
      .BUS_BYTES   (BUS_BYTES),
      .CW          (CW),
      .NW          (NW)
   ) i_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .csr_we    (csr_we),
      .csr_wdata (csr_wdata),
      .dat_we    (dat_we),
      .core_busy (core_busy),
      .rdy       (rdy),
      .blk_valid (blk_valid),
      .wr_en     (wr_en),
      .pos       (pos),
      .nbytes    (nbytes),
      .swap      (swap),
      .err       (err),
      .sum_vld   (sum_vld),
      .size      (size),
      .core_init (core_init)
   );

   hi_lane_order #(
      .BUS_BYTES (BUS_BYTES),
      .NW        (NW)
   ) i_order (
      .data   (dat_wdata),
      .nbytes (nbytes),
      .swap   (swap),
      .stream (stream)
   );

   hi_block_buf #(
      .BLOCK_BYTES (BLOCK_BYTES),
      .BUS_BYTES   (BUS_BYTES),
      .CW          (CW),
      .NW          (NW)
   ) i_buf (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .pos    (pos),
      .nbytes (nbytes),
      .stream (stream),
      .block  (blk_data)
   );

   always_comb begin
      csr_rdata                            = '0;
      csr_rdata[CSR_ERR]                   = err;
      csr_rdata[CSR_RDY]                   = rdy;
      csr_rdata[CSR_SUM]                   = sum_vld;
      csr_rdata[CSR_SZ_LSB +: CSR_SZ_W]    = size;
      csr_rdata[CSR_BSWAP]                 = swap;
   end

   assign widx    = IW'(DIGEST_WORDS - 1) - rd_idx;
   assign rd_word = core_digest[widx*32 +: 32];

   // R4: the block held for the core is frozen while intake is stalled
   a_r4_block_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !rdy |=> $stable(blk_data));

endmodule

// File: tb/test_hash_intake.sv
`timescale 1ns/1ps
module test_hash_intake;

   localparam int LAT = 5;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         csr_we;
   logic [31:0]  csr_wdata;
   logic [31:0]  csr_rdata;
   logic         dat_we;
   logic [31:0]  dat_wdata;
   logic         blk_valid;
   logic [511:0] blk_data;
   logic         core_busy;
   logic         core_init;
   logic [255:0] core_digest;
   logic [2:0]   rd_idx;
   logic [31:0]  rd_word;

   logic         m_busy;
   int           m_cnt;
   logic [511:0] m_cap;
   logic         force_busy;

   int   tests = 0;
   int   fails = 0;
   bit   done  = 0;
   logic [7:0] exp_b [64];
   int   pos;
   int   cur_sz;
   bit   cur_sw;

   always #2.5 clk = ~clk;

   hash_intake i_hash_intake (
      .clk         (clk),
      .rst_n       (rst_n),
      .csr_we      (csr_we),
      .csr_wdata   (csr_wdata),
      .csr_rdata   (csr_rdata),
      .dat_we      (dat_we),
      .dat_wdata   (dat_wdata),
      .blk_valid   (blk_valid),
      .blk_data    (blk_data),
      .core_busy   (core_busy),
      .core_init   (core_init),
      .core_digest (core_digest),
      .rd_idx      (rd_idx),
      .rd_word     (rd_word)
   );

   function automatic logic [255:0] dfun(input logic [511:0] b);
      logic [255:0] r;
      for (int j = 0; j < 8; j++)
         r[255-32*j -: 32] = b[511-32*j -: 32] ^ b[255-32*j -: 32] ^ (32'h9e37_79b9 * 32'(j + 1));
      return r;
   endfunction

   // compression core model: accepts when idle, busy for LAT cycles
   assign core_busy = m_busy | force_busy;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy      <= 1'b0;
         m_cnt       <= 0;
         core_digest <= '0;
      end else if (blk_valid && !core_busy) begin
         m_busy <= 1'b1;
         m_cnt  <= LAT;
         m_cap  <= blk_data;
      end else if (m_busy) begin
         if (m_cnt == 1) begin
            m_busy      <= 1'b0;
            core_digest <= dfun(m_cap);
         end
         m_cnt <= m_cnt - 1;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] cfg_word(input int sz, input bit sw);
      return {19'b0, sw, 6'b0, 2'(sz), 4'b0};
   endfunction

   function automatic logic [511:0] exp_block();
      logic [511:0] r;
      for (int i = 0; i < 64; i++) r[511-8*i -: 8] = exp_b[i];
      return r;
   endfunction

   task automatic csr_write(input logic [31:0] v);
      @(negedge clk);
      csr_we = 1'b1; csr_wdata = v;
      @(negedge clk);
      csr_we = 1'b0; csr_wdata = '0;
   endtask

   task automatic set_cfg(input int sz, input bit sw);
      cur_sz = sz; cur_sw = sw;
      csr_write(cfg_word(sz, sw));
   endtask

   task automatic raw_write(input logic [31:0] d);
      @(negedge clk);
      dat_we = 1'b1; dat_wdata = d;
      @(negedge clk);
      dat_we = 1'b0; dat_wdata = '0;
   endtask

   // expected placement from R2/R3
   task automatic put(input logic [31:0] d);
      int n;
      n = (cur_sz == 0) ? 1 : (cur_sz == 1) ? 2 : 4;
      for (int k = 0; k < n; k++) begin
         if (pos + k < 64)
            exp_b[pos+k] = cur_sw ? d[8*k +: 8] : d[8*(n-1-k) +: 8];
      end
      pos = (pos + n > 64) ? 64 : pos + n;
      raw_write(d);
   endtask

   function automatic logic [31:0] pat(input int p, input int seed);
      return 32'(seed) * 32'h0100_0193 + 32'(p) * 32'h0101_0101 + 32'h0302_0100;
   endfunction

   task automatic fill(input int seed);
      while (pos < 64) put(pat(pos, seed));
   endtask

   task automatic wait_rdy(output int lowc);
      lowc = 0;
      while (csr_rdata[2] == 1'b0 && lowc < 1000) begin
         lowc++;
         @(negedge clk);
      end
   endtask

   task automatic check_block(input string tag);
      logic [511:0] e;
      int bad;
      e = exp_block();
      bad = 0;
      for (int i = 0; i < 64; i++)
         if (blk_data[511-8*i -: 8] !== e[511-8*i -: 8]) bad++;
      chk(tag, 32'(bad), 32'd0);
   endtask

   // called at the negedge just after the block-completing write
   task automatic finish_block(input string tag, input bit chk_lat);
      int lowc;
      logic [255:0] ed;
      chk({"R4 blk_valid ", tag}, 32'(blk_valid), 32'd1);
      chk({"R4 rdy low ", tag}, 32'(csr_rdata[2]), 32'd0);
      check_block({"R2 R3 block bytes ", tag});
      wait_rdy(lowc);
      if (chk_lat) chk({"R5 stall cycles ", tag}, 32'(lowc), 32'(LAT + 2));
      chk({"R7 sum valid ", tag}, 32'(csr_rdata[3]), 32'd1);
      ed = dfun(exp_block());
      for (int j = 0; j < 8; j++) begin
         rd_idx = 3'(j);
         #1;
         chk({"R10 digest word ", tag}, rd_word, ed[255-32*j -: 32]);
      end
      pos = 0;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; csr_we = 1'b0; csr_wdata = '0; dat_we = 1'b0; dat_wdata = '0;
      rd_idx = '0; force_busy = 1'b0; pos = 0; cur_sz = 0; cur_sw = 1'b1;
      for (int i = 0; i < 64; i++) exp_b[i] = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 csr reset", csr_rdata, 32'h0000_1004);
      chk("R1 blk_valid reset", 32'(blk_valid), 32'd0);
      chk("R1 core_init reset", 32'(core_init), 32'd0);

      // sweep of sizes and swap settings
      for (int sz = 0; sz < 4; sz++) begin
         for (int sw = 0; sw < 2; sw++) begin
            set_cfg(sz, sw[0]);
            put(pat(0, sz * 2 + sw));
            chk("R7 sum low after first write", 32'(csr_rdata[3]), 32'd0);
            chk("R5 ready while filling", 32'(csr_rdata[2]), 32'd1);
            fill(sz * 2 + sw);
            finish_block("sweep", 1'b1);
         end
      end

      // R9 size change mid-block keeps the count
      set_cfg(1, 1'b1);
      for (int i = 0; i < 5; i++) put(pat(i, 11));
      set_cfg(2, 1'b0);
      chk("R9 size field", 32'(csr_rdata[5:4]), 32'd2);
      chk("R9 swap field", 32'(csr_rdata[12]), 32'd0);
      while (pos < 62) put(pat(pos, 12));
      set_cfg(1, 1'b1);
      put(32'h0000_beef);
      finish_block("R9 mixed", 1'b1);

      // R4 overflow: 32-bit write at position 62
      set_cfg(0, 1'b0);
      while (pos < 62) put(pat(pos, 13));
      set_cfg(2, 1'b1);
      put(32'hd4c3_b2a1);
      finish_block("R4 overflow", 1'b1);

      // R8 start
      csr_write(cfg_word(cur_sz, cur_sw) | 32'h1);
      chk("R8 core_init pulse", 32'(core_init), 32'd1);
      chk("R8 start reads zero", 32'(csr_rdata[0]), 32'd0);
      chk("R8 start clears sum", 32'(csr_rdata[3]), 32'd0);
      @(negedge clk);
      chk("R8 core_init one cycle", 32'(core_init), 32'd0);
      set_cfg(0, 1'b1);
      for (int i = 0; i < 3; i++) put(pat(i, 14));
      csr_write(cfg_word(cur_sz, cur_sw) | 32'h1);
      chk("R8 second init pulse", 32'(core_init), 32'd1);
      pos = 0;
      fill(15);
      finish_block("R8 restart", 1'b1);

      // R6 write while stalled
      set_cfg(2, 1'b1);
      fill(16);
      chk("R6 block offered", 32'(blk_valid), 32'd1);
      raw_write(32'hffff_ffff);
      chk("R6 error set", 32'(csr_rdata[1]), 32'd1);
      begin
         int lowc;
         wait_rdy(lowc);
      end
      check_block("R6 stalled write ignored");
      chk("R6 error sticky", 32'(csr_rdata[1]), 32'd1);
      pos = 0;
      for (int i = 0; i < 3; i++) put(pat(i, 17));
      csr_write(cfg_word(cur_sz, cur_sw) | 32'h2);
      chk("R6 error cleared", 32'(csr_rdata[1]), 32'd0);
      pos = 0;
      fill(18);
      finish_block("R6 after clear", 1'b1);

      // R5 block held while the core stays busy; start ignored meanwhile
      @(negedge clk);
      force_busy = 1'b1;
      set_cfg(1, 1'b0);
      fill(19);
      for (int i = 0; i < 4; i++) begin
         chk("R5 valid held", 32'(blk_valid), 32'd1);
         @(negedge clk);
      end
      csr_write(cfg_word(cur_sz, cur_sw) | 32'h1);
      chk("R8 start ignored when stalled", 32'(core_init), 32'd0);
      chk("R5 valid held after start", 32'(blk_valid), 32'd1);
      force_busy = 1'b0;
      finish_block("R5 held", 1'b1);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule